// File: doc/BRIEF.md
# Prioritized Memory Access Controller

This block shares one external memory bus between two requesters: a video fetch engine and a CPU. Each requester offers an access with a valid/ready handshake. The controller decodes the 21-bit internal address into a device class: DRAM, fast or slow 8-bit SRAM, fast or slow I/O, or its own configuration register. It then holds the bus for that class's cycle count, drives abstract chip-select, address and data outputs, and returns the result to the owner with a one-cycle done pulse.

Back-pressure works as follows. A request stays offered, with valid high and address, write flag and data stable, until it meets ready at a clock edge. Ready is high only while no access is in flight. Once an access is accepted, both ready outputs stay low until the done pulse, so only one access is outstanding at a time. The video requester outranks the CPU whenever video is enabled. Both requesters see the same read-data value, and the done pulse tells each one whether it is the owner.

The configuration register does two jobs. Its lowest bit turns the video requester on or off. Its two top bits are the page bits that supply the upper SRAM address lines.

Top module: `prio_mem_ctrl`

## Requirements
- R1: After reset no chip select, row strobe or done pulse is active, the configuration register is zero (so video ready is low), and CPU ready is high.
- R2: When video is enabled and both requesters are valid in an idle cycle, only video ready is high. When an access ends while a video request is pending, video ready is high in the same cycle as the done pulse of the ending access.
- R3: While configuration bit 0 is zero, video ready stays low, no video access starts, and a valid video request does not block the CPU.
- R4: An address with bit 20 clear is a DRAM access lasting DRAM_CYC cycles. During the first ceil(DRAM_CYC/2) of those cycles the row strobe is high and mem_addr[9:0] carries address bits 19..10. During the remaining cycles mem_addr[9:0] carries address bits 9..0. mem_addr[19:10] is zero throughout.
- R5: With bit 20 set, bits 20..17 select the target: 1001 slow I/O, 1010 configuration register, 1011 fast I/O, 110x fast SRAM, 111x slow SRAM. At most one chip select is active at a time.
- R6: On an SRAM access, mem_addr is {cfg[19:18], address[17:0]}. Only the low 8 bits of write data are driven; the upper bits are zero. Read data is mem_rdata[7:0] zero-extended.
- R7: Fast SRAM and fast I/O accesses hold their select for FAST_CYC cycles. Slow SRAM and slow I/O accesses hold it for SLOW_CYC cycles.
- R8: A configuration-register access takes one cycle and drives no chip select. A write stores the full write word; a read returns the stored value.
- R9: The owner's done pulse lasts one cycle and arrives N+1 clock edges after the accepting edge, where N is the access length. The read data is valid in the same cycle as the pulse.
- R10: An address that falls in no region (bits 20..17 = 1000, or an I/O address with bits 16..10 nonzero) completes after one cycle with read data zero and no chip select.
- R11: On an I/O access, mem_addr is zero above bit 9 and carries address bits 9..0 below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_req_valid | input | 1 | Video request offered |
| vid_req_ready | output | 1 | Video request can be accepted |
| vid_req_addr | input | 21 | Video read address |
| vid_done | output | 1 | One-cycle completion pulse for video |
| vid_rdata | output | 20 | Read data, valid with vid_done |
| cpu_req_valid | input | 1 | CPU request offered |
| cpu_req_ready | output | 1 | CPU request can be accepted |
| cpu_req_addr | input | 21 | CPU address |
| cpu_req_we | input | 1 | CPU write flag |
| cpu_req_wdata | input | 20 | CPU write data |
| cpu_done | output | 1 | One-cycle completion pulse for CPU |
| cpu_rdata | output | 20 | Read data, valid with cpu_done |
| mem_cs_dram | output | 1 | DRAM select |
| mem_cs_sram | output | 1 | SRAM select |
| mem_cs_io | output | 1 | I/O select |
| mem_row | output | 1 | DRAM row phase strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 20 | Device address (muxed halves for DRAM) |
| mem_wdata | output | 20 | Device write data |
| mem_rdata | input | 20 | Device read data |

## Verification
Each access is accepted at the clock edge where valid meets ready. Bus activity starts in the cycle after that edge and lasts N cycles. The done pulse and read data appear one cycle after the bus activity ends, which is N+1 edges after acceptance. The bench drives inputs on falling edges and samples on falling edges. It counts falling edges from the accepting edge, so each measured latency, select count and row-phase count can be compared with exact values computed from the cycle parameters. Ready outputs depend combinationally on the valid inputs, so the bench waits a short delay after driving before it samples them.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    TG_NONE, TG_DRAM, TG_SIO, TG_CFG, TG_FIO, TG_FSRAM, TG_SSRAM
  } tgt_e;
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int AW       = 21,
  parameter int DW       = 20,
  parameter int IOW      = 10,
  parameter int PGW      = 2,
  parameter int DRAM_CYC = 5,
  parameter int SLOW_CYC = 25,
  parameter int FAST_CYC = 2,
  parameter int CW       = 5
) (
  input  logic [AW-1:0]  addr,
  input  logic [PGW-1:0] page,
  output tgt_e           tgt,
  output logic [CW-1:0]  len,
  output logic [DW-1:0]  phys
);
  localparam int RB = AW - 4;   // lowest region-select bit

  logic io_ok;
  assign io_ok = (addr[RB-1:IOW] == '0);

  always_comb begin
    tgt  = TG_NONE;
    len  = CW'(1);
    phys = '0;
    if (!addr[AW-1]) begin
      tgt  = TG_DRAM;
      len  = CW'(DRAM_CYC);
      phys = addr[DW-1:0];
    end else begin
      unique casez (addr[AW-2:RB])
        3'b001: if (io_ok) begin
          tgt = TG_SIO; len = CW'(SLOW_CYC);
          phys = {{(DW-IOW){1'b0}}, addr[IOW-1:0]};
        end
        3'b010: tgt = TG_CFG;
        3'b011: if (io_ok) begin
          tgt = TG_FIO; len = CW'(FAST_CYC);
          phys = {{(DW-IOW){1'b0}}, addr[IOW-1:0]};
        end
        3'b10?: begin
          tgt = TG_FSRAM; len = CW'(FAST_CYC);
          phys = {page, addr[DW-PGW-1:0]};
        end
        3'b11?: begin
          tgt = TG_SSRAM; len = CW'(SLOW_CYC);
          phys = {page, addr[DW-PGW-1:0]};
        end
        default: tgt = TG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pmc_arb.sv
module pmc_arb (
  input  logic idle,
  input  logic vid_en,
  input  logic vid_valid,
  input  logic cpu_valid,
  output logic vid_ready,
  output logic cpu_ready,
  output logic accept,
  output logic pick_vid
);
  assign vid_ready = idle && vid_en;
  assign cpu_ready = idle && !(vid_en && vid_valid);
  assign pick_vid  = vid_ready && vid_valid;
  assign accept    = pick_vid || (cpu_ready && cpu_valid);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int DW       = 20,
  parameter int BYTEW    = 8,
  parameter int DRAM_CYC = 5,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          acc_vid,
  input  logic          acc_we,
  input  logic [DW-1:0] acc_wdata,
  input  tgt_e          acc_tgt,
  input  logic [CW-1:0] acc_len,
  input  logic [DW-1:0] acc_phys,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [DW-1:0] cfg_q,
  output logic          cpu_done,
  output logic          vid_done,
  output logic [DW-1:0] rdata,
  output logic          mem_cs_dram,
  output logic          mem_cs_sram,
  output logic          mem_cs_io,
  output logic          mem_row,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int HALF    = DW / 2;
  localparam int ROW_CYC = (DRAM_CYC + 1) / 2;

  logic [CW-1:0] el_q, len_q;
  logic [DW-1:0] phys_q, wdata_q, rsel;
  logic          we_q, vid_q, last, dev;
  tgt_e          tgt_q;

  assign last = busy && ((el_q + CW'(1)) == len_q);

  assign mem_cs_dram = busy && (tgt_q == TG_DRAM);
  assign mem_cs_sram = busy && (tgt_q == TG_FSRAM || tgt_q == TG_SSRAM);
  assign mem_cs_io   = busy && (tgt_q == TG_SIO || tgt_q == TG_FIO);
  assign dev         = mem_cs_dram || mem_cs_sram || mem_cs_io;
  assign mem_row     = mem_cs_dram && (el_q < CW'(ROW_CYC));
  assign mem_we      = dev && we_q;

  always_comb begin
    mem_addr = '0;
    if (mem_cs_dram)
      mem_addr = mem_row ? {{(DW-HALF){1'b0}}, phys_q[DW-1:HALF]}
                         : {{(DW-HALF){1'b0}}, phys_q[HALF-1:0]};
    else if (dev)
      mem_addr = phys_q;
  end

  always_comb begin
    mem_wdata = '0;
    if (mem_we)
      mem_wdata = mem_cs_sram ? {{(DW-BYTEW){1'b0}}, wdata_q[BYTEW-1:0]} : wdata_q;
  end

  always_comb begin
    unique case (tgt_q)
      TG_NONE:            rsel = '0;
      TG_CFG:             rsel = cfg_q;
      TG_FSRAM, TG_SSRAM: rsel = {{(DW-BYTEW){1'b0}}, mem_rdata[BYTEW-1:0]};
      default:            rsel = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      el_q     <= '0;
      len_q    <= '0;
      tgt_q    <= TG_NONE;
      phys_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      vid_q    <= 1'b0;
      cfg_q    <= '0;
      cpu_done <= 1'b0;
      vid_done <= 1'b0;
      rdata    <= '0;
    end else begin
      cpu_done <= 1'b0;
      vid_done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        el_q    <= '0;
        len_q   <= acc_len;
        tgt_q   <= acc_tgt;
        phys_q  <= acc_phys;
        wdata_q <= acc_wdata;
        we_q    <= acc_we;
        vid_q   <= acc_vid;
      end else if (busy) begin
        if (last) begin
          busy     <= 1'b0;
          rdata    <= rsel;
          cpu_done <= !vid_q;
          vid_done <= vid_q;
          if (tgt_q == TG_CFG && we_q) cfg_q <= wdata_q;
        end else begin
          el_q <= el_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/prio_mem_ctrl.sv
module prio_mem_ctrl
  import pmc_pkg::*;
#(
  parameter int AW       = 21,
  parameter int DW       = 20,
  parameter int IOW      = 10,
  parameter int BYTEW    = 8,
  parameter int DRAM_CYC = 5,
  parameter int SLOW_CYC = 25,
  parameter int FAST_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_req_valid,
  output logic          vid_req_ready,
  input  logic [AW-1:0] vid_req_addr,
  output logic          vid_done,
  output logic [DW-1:0] vid_rdata,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic          cpu_req_we,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_cs_dram,
  output logic          mem_cs_sram,
  output logic          mem_cs_io,
  output logic          mem_row,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PGW  = 2;
  localparam int MAXC = (SLOW_CYC > DRAM_CYC) ? ((SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC)
                                              : ((DRAM_CYC > FAST_CYC) ? DRAM_CYC : FAST_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy, accept, pick_vid;
  logic [DW-1:0] cfg_q, rdata;
  logic [AW-1:0] sel_addr;
  tgt_e          dec_tgt;
  logic [CW-1:0] dec_len;
  logic [DW-1:0] dec_phys;

  pmc_arb i_arb (
    .idle      (!busy),
    .vid_en    (cfg_q[0]),
    .vid_valid (vid_req_valid),
    .cpu_valid (cpu_req_valid),
    .vid_ready (vid_req_ready),
    .cpu_ready (cpu_req_ready),
    .accept    (accept),
    .pick_vid  (pick_vid)
  );

  assign sel_addr = pick_vid ? vid_req_addr : cpu_req_addr;

  pmc_decode #(
    .AW(AW), .DW(DW), .IOW(IOW), .PGW(PGW),
    .DRAM_CYC(DRAM_CYC), .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC), .CW(CW)
  ) i_dec (
    .addr (sel_addr),
    .page (cfg_q[DW-1:DW-PGW]),
    .tgt  (dec_tgt),
    .len  (dec_len),
    .phys (dec_phys)
  );

  pmc_seq #(.DW(DW), .BYTEW(BYTEW), .DRAM_CYC(DRAM_CYC), .CW(CW)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .acc_vid     (pick_vid),
    .acc_we      (pick_vid ? 1'b0 : cpu_req_we),
    .acc_wdata   (cpu_req_wdata),
    .acc_tgt     (dec_tgt),
    .acc_len     (dec_len),
    .acc_phys    (dec_phys),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .cfg_q       (cfg_q),
    .cpu_done    (cpu_done),
    .vid_done    (vid_done),
    .rdata       (rdata),
    .mem_cs_dram (mem_cs_dram),
    .mem_cs_sram (mem_cs_sram),
    .mem_cs_io   (mem_cs_io),
    .mem_row     (mem_row),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  assign cpu_rdata = rdata;
  assign vid_rdata = rdata;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int DW  = 20,
  parameter int IOW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vid_req_valid,
  input logic          vid_req_ready,
  input logic          cpu_req_valid,
  input logic          cpu_req_ready,
  input logic          cpu_done,
  input logic          vid_done,
  input logic          mem_cs_dram,
  input logic          mem_cs_sram,
  input logic          mem_cs_io,
  input logic          mem_row,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] cfg
);
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_req_valid && vid_req_ready && cpu_req_valid && cpu_req_ready)); // R2
  AST_VIDEO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_ready && vid_req_valid) |-> !cfg[0]); // R2
  AST_VIDEO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] |-> !vid_req_ready); // R3
  AST_ROW_IN_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_row |-> mem_cs_dram); // R4
  AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_row) |-> mem_cs_dram); // R4
  AST_DRAM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_dram |-> (mem_addr[DW-1:DW/2] == '0)); // R4
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_cs_dram, mem_cs_sram, mem_cs_io})); // R5
  AST_SRAM_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_sram |-> (mem_addr[DW-1:DW-2] == cfg[DW-1:DW-2])); // R6
  AST_CPU_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R9
  AST_VID_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_done |=> !vid_done); // R9
  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_dram || mem_cs_sram || mem_cs_io) |-> !(cpu_req_ready || vid_req_ready)); // R9
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_io |-> (mem_addr[DW-1:IOW] == '0)); // R11
endmodule

bind prio_mem_ctrl pmc_chk #(.DW(DW), .IOW(IOW)) i_pmc_chk (
  .clk(clk), .rst_n(rst_n),
  .vid_req_valid(vid_req_valid), .vid_req_ready(vid_req_ready),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_done(cpu_done), .vid_done(vid_done),
  .mem_cs_dram(mem_cs_dram), .mem_cs_sram(mem_cs_sram), .mem_cs_io(mem_cs_io),
  .mem_row(mem_row), .mem_addr(mem_addr), .cfg(cfg_q)
);

// File: tb/test_prio_mem_ctrl.sv
`timescale 1ns/1ps
module test_prio_mem_ctrl;
  localparam int DRAM_CYC = 5, SLOW_CYC = 25, FAST_CYC = 2;
  localparam int ROWC = (DRAM_CYC + 1) / 2;
  localparam logic [19:0] KEY = 20'hA5C3E;
  localparam logic [20:0] CFG_A = 21'h140000;
  // class codes: 0 none, 1 cfg, 2 dram, 3 sram, 4 io
  localparam int NV = 11;
  // {addr[20:0], we, wdata[19:0], cls[2:0], len[4:0]}
  localparam logic [49:0] VEC [NV] = '{
    {21'h140000, 1'b1, 20'h80000, 3'd1, 5'd1},
    {21'h140000, 1'b0, 20'h00000, 3'd1, 5'd1},
    {21'h0ABCDE, 1'b0, 20'h00000, 3'd2, 5'(DRAM_CYC)},
    {21'h001234, 1'b1, 20'h5A5A5, 3'd2, 5'(DRAM_CYC)},
    {21'h1A1234, 1'b0, 20'h00000, 3'd3, 5'(FAST_CYC)},
    {21'h1E00FF, 1'b1, 20'hFFF3C, 3'd3, 5'(SLOW_CYC)},
    {21'h1203FF, 1'b0, 20'h00000, 3'd4, 5'(SLOW_CYC)},
    {21'h160155, 1'b1, 20'h12345, 3'd4, 5'(FAST_CYC)},
    {21'h100010, 1'b0, 20'h00000, 3'd0, 5'd1},
    {21'h120400, 1'b0, 20'h00000, 3'd0, 5'd1},
    {21'h0FFFFF, 1'b0, 20'h00000, 3'd2, 5'(DRAM_CYC)}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vid_req_valid = 1'b0, cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [20:0] vid_req_addr = '0, cpu_req_addr = '0;
  logic [19:0] cpu_req_wdata = '0;
  logic vid_req_ready, cpu_req_ready, vid_done, cpu_done;
  logic [19:0] vid_rdata, cpu_rdata;
  logic mem_cs_dram, mem_cs_sram, mem_cs_io, mem_row, mem_we;
  logic [19:0] mem_addr, mem_wdata, mem_rdata;
  int checks = 0, failures = 0, cycles = 0;
  logic [19:0] cfg_sh = '0;

  always #10 clk = ~clk;
  assign mem_rdata = mem_addr ^ KEY;

  prio_mem_ctrl #(.DRAM_CYC(DRAM_CYC), .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) i_prio_mem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .vid_req_valid(vid_req_valid), .vid_req_ready(vid_req_ready), .vid_req_addr(vid_req_addr),
    .vid_done(vid_done), .vid_rdata(vid_rdata),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_addr(cpu_req_addr),
    .cpu_req_we(cpu_req_we), .cpu_req_wdata(cpu_req_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_cs_dram(mem_cs_dram), .mem_cs_sram(mem_cs_sram), .mem_cs_io(mem_cs_io),
    .mem_row(mem_row), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [2:0] cs_cls();
    if (mem_cs_dram) return 3'd2;
    if (mem_cs_sram) return 3'd3;
    if (mem_cs_io)   return 3'd4;
    return 3'd0;
  endfunction

  // One CPU access; reports latency in falling edges after the accepting edge.
  task automatic cpu_acc(input logic [20:0] a, input logic we, input logic [19:0] wd,
                         output int lat, output int nstb, output int nrow, output logic [2:0] cls,
                         output logic [19:0] afirst, output logic [19:0] alast,
                         output logic [19:0] wfirst, output logic [19:0] rd, output logic dn_next);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_we = we; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    lat = 0; nstb = 0; nrow = 0; cls = 3'd0; afirst = '0; alast = '0; wfirst = '0; rd = '0;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (k == 1) cpu_req_valid = 1'b0;
      if (mem_cs_dram || mem_cs_sram || mem_cs_io) begin
        nstb++;
        if (nstb == 1) begin cls = cs_cls(); afirst = mem_addr; wfirst = mem_wdata; end
        alast = mem_addr;
      end
      if (mem_row) nrow++;
      if (cpu_done) begin lat = k; rd = cpu_rdata; break; end
    end
    @(negedge clk);
    dn_next = cpu_done;
  endtask

  initial begin
    int lat, nstb, nrow;
    logic [2:0] cls;
    logic [19:0] af, al, wf, rd, ea, ed;
    logic dn, flag;
    // R1 reset state
    #1;
    chk(!mem_cs_dram && !mem_cs_sram && !mem_cs_io && !mem_row, "R1 selects", {29'd0, cs_cls()}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cpu_done && !vid_done, "R1 done", {cpu_done, vid_done}, 0);
    chk(!vid_req_ready, "R1 video ready", vid_req_ready, 0);
    chk(cpu_req_ready, "R1 cpu ready", cpu_req_ready, 1);

    // Vector walk: R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [20:0] a;
      logic we;
      logic [19:0] wd;
      logic [2:0] c;
      int n;
      {a, we, wd, c, n} = {VEC[i][49:29], VEC[i][28], VEC[i][27:8], VEC[i][7:5], 32'(VEC[i][4:0])};
      cpu_acc(a, we, wd, lat, nstb, nrow, cls, af, al, wf, rd, dn);
      chk(lat == n + 1, $sformatf("R9 latency v%0d", i), lat, n + 1);
      chk(!dn, $sformatf("R9 single pulse v%0d", i), dn, 0);
      chk(nstb == ((c >= 3'd2) ? n : 0), $sformatf("R7 select length v%0d", i), nstb, (c >= 3'd2) ? n : 0);
      chk(cls == ((c >= 3'd2) ? c : 3'd0), $sformatf("R5 target v%0d", i), cls, c);
      case (c)
        3'd0: chk(rd == '0, $sformatf("R10 unmapped read v%0d", i), rd, 0);
        3'd1: begin
          if (we) cfg_sh = wd;
          else chk(rd == cfg_sh, $sformatf("R8 cfg read v%0d", i), rd, cfg_sh);
        end
        3'd2: begin
          chk(nrow == ROWC, $sformatf("R4 row cycles v%0d", i), nrow, ROWC);
          chk(af == {10'd0, a[19:10]}, $sformatf("R4 row addr v%0d", i), af, {10'd0, a[19:10]});
          chk(al == {10'd0, a[9:0]}, $sformatf("R4 col addr v%0d", i), al, {10'd0, a[9:0]});
          if (we) chk(wf == wd, $sformatf("R4 dram wdata v%0d", i), wf, wd);
          else chk(rd == ({10'd0, a[9:0]} ^ KEY), $sformatf("R4 dram read v%0d", i), rd, {10'd0, a[9:0]} ^ KEY);
        end
        3'd3: begin
          ea = {cfg_sh[19:18], a[17:0]};
          chk(af == ea, $sformatf("R6 sram page addr v%0d", i), af, ea);
          if (we) chk(wf == {12'd0, wd[7:0]}, $sformatf("R6 byte lane write v%0d", i), wf, {12'd0, wd[7:0]});
          else begin
            ed = {12'd0, ea[7:0] ^ KEY[7:0]};
            chk(rd == ed, $sformatf("R6 byte lane read v%0d", i), rd, ed);
          end
        end
        default: begin
          ea = {10'd0, a[9:0]};
          chk(af == ea, $sformatf("R11 io addr v%0d", i), af, ea);
          if (we) chk(wf == wd, $sformatf("R11 io wdata v%0d", i), wf, wd);
          else chk(rd == (ea ^ KEY), $sformatf("R11 io read v%0d", i), rd, ea ^ KEY);
        end
      endcase
    end

    // R3: video disabled (cfg bit0 = 0), CPU not blocked
    @(negedge clk);
    vid_req_valid = 1'b1; vid_req_addr = 21'h000040; flag = 1'b0;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (vid_req_ready || vid_done) flag = 1'b1;
      if (k == 0) chk(cpu_req_ready, "R3 cpu not blocked", cpu_req_ready, 1);
      @(negedge clk);
    end
    chk(!flag, "R3 video ignored while disabled", flag, 0);
    vid_req_valid = 1'b0;

    // enable video, keep page
    cpu_acc(CFG_A, 1'b1, 20'h80001, lat, nstb, nrow, cls, af, al, wf, rd, dn);
    cfg_sh = 20'h80001;

    // R2: simultaneous requests, video first, CPU right after
    @(negedge clk);
    vid_req_valid = 1'b1; vid_req_addr = 21'h0003FF;
    cpu_req_valid = 1'b1; cpu_req_addr = 21'h000010; cpu_req_we = 1'b0;
    #1;
    chk(vid_req_ready, "R2 video ready on tie", vid_req_ready, 1);
    chk(!cpu_req_ready, "R2 cpu held on tie", cpu_req_ready, 0);
    @(posedge clk);
    flag = 1'b0; lat = 0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (k == 1) vid_req_valid = 1'b0;
      #1;
      if (vid_done) begin lat = k; break; end
      if (cpu_req_ready) flag = 1'b1;
    end
    chk(lat == DRAM_CYC + 1, "R9 video latency", lat, DRAM_CYC + 1);
    chk(vid_rdata == (20'h003FF ^ KEY), "R2 video read data", vid_rdata, 20'h003FF ^ KEY);
    chk(!flag, "R2 cpu held during video", flag, 0);
    chk(cpu_req_ready, "R2 cpu ready at video done", cpu_req_ready, 1);
    @(posedge clk);
    lat = 0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (k == 1) cpu_req_valid = 1'b0;
      if (cpu_done) begin lat = k; rd = cpu_rdata; break; end
    end
    chk(rd == (20'h00010 ^ KEY), "R2 cpu served after video", rd, 20'h00010 ^ KEY);

    // R2: video pending during slow CPU access, granted when it ends
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = 21'h120005; cpu_req_we = 1'b0;
    #1;
    @(posedge clk);
    flag = 1'b0;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (k == 1) begin cpu_req_valid = 1'b0; vid_req_valid = 1'b1; vid_req_addr = 21'h000020; end
      #1;
      if (cpu_done) break;
      if (vid_req_ready) flag = 1'b1;
    end
    chk(!flag, "R2 video waits for busy bus", flag, 0);
    chk(vid_req_ready, "R2 video ready at cpu done", vid_req_ready, 1);
    @(posedge clk);
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (k == 1) vid_req_valid = 1'b0;
      if (vid_done) begin rd = vid_rdata; break; end
    end
    chk(rd == (20'h00020 ^ KEY), "R2 pending video served", rd, 20'h00020 ^ KEY);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule